// File: doc/BRIEF.md
# Dual-Source Power Path Arbiter

This block is the digital controller of a two-input, one-output power selector. Two comparators outside the block report whether each input supply sits inside its valid window. The block debounces those levels and picks which pass switch may conduct. It drives the gate enables of the two pass switches and an output-discharge enable. Channel 1 is the primary source and channel 2 is the secondary one. All timers count cycles of a fixed slow clock.

A mode input chooses between two kinds of operation. In autonomous operation the block arbitrates by itself. It gives priority to channel 1, and a deglitched lock input can freeze the current choice. Whenever the block leaves a conducting channel, both switches stay off for a break-before-make gap while the output is actively discharged. The channel-1 enable input, together with a valid output voltage, also requests reverse conduction from the output back to the channel-1 input. The wait before that reverse path turns on is longer when a channel-2 supply is present.

In slave operation the channel-1 enable input and the bidirectional channel-2 pin drive the switches directly, and the channel-2 pin can turn on both channels at once. In autonomous operation the block uses that pin as an open-drain status output. An over-temperature input forces both channels off, and the block recovers on its own once the input clears.

Top module: `psel_arbiter`

## Requirements
- R1: `mode_slave_i` high selects slave operation and low selects autonomous operation. A change of mode takes effect on the next clock edge. On return to autonomous operation the sequencer starts from idle, with no channel selected.
- R2: A channel can be enabled only after its valid input (`a_ok_i`, `b_ok_i`) has been high for `DEB_CYC` consecutive edges. A valid pulse shorter than that enables nothing.
- R3: In autonomous operation, channel 1 wins when both inputs are valid, and channel 2 is used when only it is valid. While channel 2 conducts and the switches are not locked, a newly qualified channel 1 takes over through a break-before-make gap.
- R4: When the valid input of a conducting channel falls, that channel's gate turns off at the next clock edge, with no debounce.
- R5: When a conducting channel is left in autonomous operation, `dischg_o` is high for exactly `BBM_CYC` cycles. Both gates stay off for at least `BBM_CYC + 1` cycles. `dischg_o` is never high while a gate is on.
- R6: The lock input counts only after it has held the same level for `LOCK_CYC` consecutive edges, and shorter pulses are ignored. While the qualified lock is high, the block never moves from one channel to the other.
- R7: After a conducting channel drops out while locked, only that same channel may be re-entered until the lock is released.
- R8: In autonomous operation `b_pin_pd_o` is 0 (pin released, reads high) exactly while channel 2 conducts, and 1 otherwise. In autonomous operation the pin level `b_pin_i` has no effect on the gates. In slave operation `b_pin_pd_o` is 0.
- R9: In slave operation `gate_a_o` equals (channel 1 qualified) AND (`a_en_i` OR `b_pin_i`), and `gate_b_o` equals (channel 2 qualified) AND `b_pin_i`. Both follow one edge after the inputs.
- R10: In autonomous operation, from idle, `a_en_i` and `out_ok_i` both high start reverse conduction. After a wait of `OTG_WAIT_B` edges if `b_ok_i` was high at the request, or `OTG_WAIT_NB` edges otherwise, `gate_a_o` and `otg_rev_o` rise one edge later. Channel 2 is ignored meanwhile. Dropping the request leaves reverse conduction through a gap.
- R11: `over_temp_i` high turns both gates off at the next edge. Once it is low again, autonomous selection resumes from idle, so a valid channel is back on two edges after the clear.
- R12: `gate_a_o` and `gate_b_o` are high together only in slave operation with `b_pin_i` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_ok_i | input | 1 | Channel-1 supply inside its valid window |
| b_ok_i | input | 1 | Channel-2 supply inside its valid window |
| out_ok_i | input | 1 | Output node voltage valid (reverse conduction) |
| mode_slave_i | input | 1 | 1 = slave operation, 0 = autonomous |
| lock_i | input | 1 | Switch-over lock request (deglitched) |
| a_en_i | input | 1 | Channel-1 enable / reverse-conduction request |
| b_pin_i | input | 1 | Level sampled on the bidirectional channel-2 pin |
| over_temp_i | input | 1 | Over-temperature indication |
| gate_a_o | output | 1 | Channel-1 pass switch enable |
| gate_b_o | output | 1 | Channel-2 pass switch enable |
| dischg_o | output | 1 | Output discharge enable |
| otg_rev_o | output | 1 | Channel 1 conducting in reverse direction |
| b_pin_pd_o | output | 1 | Open-drain pull-down on the channel-2 pin |

## Verification
The bench goes after the exact cycle counts of the debounce, the gap and the two reverse-conduction waits. A design off by one edge would switch early, or would cut the discharge window short. It checks that a lock pulse one cycle too short is rejected. It checks that re-entry after a locked drop-out goes only to the former channel, because a design that forgets the last selection would silently swap supplies with the lock set. It also checks that a channel-2 supply arriving during the reverse wait does not take over. Finally, it checks that the channel-2 pin turns on both channels only in slave operation; a design that let it do so in autonomous operation would short the two sources together.

// File: rtl/psel_pkg.sv
package psel_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FWD_A,
    ST_FWD_B,
    ST_GAP,
    ST_OTG_WAIT,
    ST_OTG_ON
  } arb_state_t;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_A,
    SRC_B
  } src_t;

  // Reverse-path wait: longer when a channel-2 supply is present
  function automatic int unsigned otg_wait_cycles(input logic b_present,
                                                  input int unsigned w_with_b,
                                                  input int unsigned w_alone);
    return b_present ? w_with_b : w_alone;
  endfunction

  // A channel may be entered if unlocked, or if it was the last one used
  function automatic logic may_enter(input src_t last, input logic locked,
                                     input src_t cand);
    return !locked || (last == SRC_NONE) || (last == cand);
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/psel_qualifier.sv
module psel_qualifier #(
  parameter int unsigned LEN       = 15,
  parameter bit          SYMMETRIC = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic ok_o
);
  localparam int unsigned CW  = (LEN < 2) ? 1 : $clog2(LEN + 1);
  localparam logic [CW-1:0] LAST = CW'(LEN - 1);

  logic [CW-1:0] cnt;
  logic          q;

  generate
    if (SYMMETRIC) begin : g_sym
      // Output follows the input after LEN stable edges in either direction
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
          q   <= 1'b0;
        end else if (in_i == q) begin
          cnt <= '0;
        end else if (cnt == LAST) begin
          cnt <= '0;
          q   <= in_i;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      assign ok_o = q;
    end else begin : g_rise
      // Qualify on rise only; a falling input clears at once
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt <= '0;
          q   <= 1'b0;
        end else if (!in_i) begin
          cnt <= '0;
          q   <= 1'b0;
        end else if (!q) begin
          if (cnt == LAST) q <= 1'b1;
          else             cnt <= cnt + 1'b1;
        end
      end
      assign ok_o = q & in_i;
    end
  endgenerate

  // R2 / R6: the qualified level only rises on an input seen high
  assert_rise_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q) |-> $past(in_i));

endmodule

// File: rtl/psel_sequencer.sv
module psel_sequencer
  import psel_pkg::*;
#(
  parameter int unsigned BBM_CYC     = 30,
  parameter int unsigned OTG_WAIT_B  = 15,
  parameter int unsigned OTG_WAIT_NB = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic va_i,
  input  logic vb_i,
  input  logic lock_i,
  input  logic otg_req_i,
  input  logic b_raw_i,
  output logic fwd_a_o,
  output logic fwd_b_o,
  output logic dischg_o,
  output logic otg_o
);
  localparam int unsigned MAXL = max3(BBM_CYC, OTG_WAIT_B, OTG_WAIT_NB);
  localparam int unsigned CW   = (MAXL < 2) ? 1 : $clog2(MAXL + 1);
  localparam logic [CW-1:0] GAP_LAST = CW'(BBM_CYC - 1);

  arb_state_t    st, st_n;
  src_t          last, last_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [CW-1:0] wlen, wlen_n;

  // Named events for the checks below
  logic gap_done, otg_ready;
  assign gap_done  = (cnt == GAP_LAST);
  assign otg_ready = (cnt == wlen - 1'b1);

  always_comb begin
    st_n   = st;
    last_n = last;
    cnt_n  = cnt;
    wlen_n = wlen;
    unique case (st)
      ST_IDLE: begin
        cnt_n = '0;
        if (otg_req_i) begin
          st_n   = ST_OTG_WAIT;
          wlen_n = CW'(otg_wait_cycles(b_raw_i, OTG_WAIT_B, OTG_WAIT_NB));
        end else if (va_i && may_enter(last, lock_i, SRC_A)) begin
          st_n   = ST_FWD_A;
          last_n = SRC_A;
        end else if (vb_i && may_enter(last, lock_i, SRC_B)) begin
          st_n   = ST_FWD_B;
          last_n = SRC_B;
        end
      end
      ST_FWD_A: begin
        cnt_n = '0;
        if (!va_i) st_n = ST_GAP;
      end
      ST_FWD_B: begin
        cnt_n = '0;
        if (!vb_i || (va_i && !lock_i)) st_n = ST_GAP;
      end
      ST_GAP: begin
        if (gap_done) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_OTG_WAIT: begin
        if (!otg_req_i) begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end else if (otg_ready) begin
          st_n  = ST_OTG_ON;
          cnt_n = '0;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      ST_OTG_ON: begin
        cnt_n = '0;
        if (!otg_req_i) st_n = ST_GAP;
      end
      default: begin
        st_n  = ST_IDLE;
        cnt_n = '0;
      end
    endcase
    if (hold_i) begin
      st_n   = ST_IDLE;
      last_n = SRC_NONE;
      cnt_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      last <= SRC_NONE;
      cnt  <= '0;
      wlen <= CW'(1);
    end else begin
      st   <= st_n;
      last <= last_n;
      cnt  <= cnt_n;
      wlen <= wlen_n;
    end
  end

  assign fwd_a_o  = (st == ST_FWD_A) || (st == ST_OTG_ON);
  assign fwd_b_o  = (st == ST_FWD_B);
  assign dischg_o = (st == ST_GAP);
  assign otg_o    = (st == ST_OTG_ON);

  // R4: a dropped channel-1 supply leaves conduction at the next edge
  assert_drop_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FWD_A && !va_i && !hold_i) |=> (st == ST_GAP));

  // R6: qualified lock keeps channel 2 selected despite a valid channel 1
  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FWD_B && lock_i && vb_i && !hold_i) |=> (st == ST_FWD_B));

  // R5: the gap never hands over straight to a conducting state
  assert_gap_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_GAP) |=> (st == ST_GAP || st == ST_IDLE));

endmodule

// File: rtl/psel_arbiter.sv
module psel_arbiter
  import psel_pkg::*;
#(
  parameter int unsigned DEB_CYC     = 15,
  parameter int unsigned LOCK_CYC    = 10,
  parameter int unsigned BBM_CYC     = 30,
  parameter int unsigned OTG_WAIT_B  = 15,
  parameter int unsigned OTG_WAIT_NB = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic a_ok_i,
  input  logic b_ok_i,
  input  logic out_ok_i,
  input  logic mode_slave_i,
  input  logic lock_i,
  input  logic a_en_i,
  input  logic b_pin_i,
  input  logic over_temp_i,
  output logic gate_a_o,
  output logic gate_b_o,
  output logic dischg_o,
  output logic otg_rev_o,
  output logic b_pin_pd_o
);

  logic va, vb, lk;
  logic slave_q, ot_q, pin_q, slv_a_q, slv_b_q;
  logic seq_a, seq_b, seq_dis, seq_otg;
  logic hold, otg_req;

  psel_qualifier #(.LEN(DEB_CYC), .SYMMETRIC(1'b0)) u_qual_a (
    .clk(clk), .rst_n(rst_n), .in_i(a_ok_i), .ok_o(va));
  psel_qualifier #(.LEN(DEB_CYC), .SYMMETRIC(1'b0)) u_qual_b (
    .clk(clk), .rst_n(rst_n), .in_i(b_ok_i), .ok_o(vb));
  psel_qualifier #(.LEN(LOCK_CYC), .SYMMETRIC(1'b1)) u_qual_lock (
    .clk(clk), .rst_n(rst_n), .in_i(lock_i), .ok_o(lk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slave_q <= 1'b0;
      ot_q    <= 1'b0;
      pin_q   <= 1'b0;
      slv_a_q <= 1'b0;
      slv_b_q <= 1'b0;
    end else begin
      slave_q <= mode_slave_i;
      ot_q    <= over_temp_i;
      pin_q   <= b_pin_i;
      slv_a_q <= va & (a_en_i | b_pin_i);
      slv_b_q <= vb & b_pin_i;
    end
  end

  assign hold    = slave_q | ot_q;
  assign otg_req = a_en_i & out_ok_i;

  psel_sequencer #(
    .BBM_CYC(BBM_CYC), .OTG_WAIT_B(OTG_WAIT_B), .OTG_WAIT_NB(OTG_WAIT_NB)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .hold_i(hold), .va_i(va), .vb_i(vb),
    .lock_i(lk), .otg_req_i(otg_req), .b_raw_i(b_ok_i),
    .fwd_a_o(seq_a), .fwd_b_o(seq_b), .dischg_o(seq_dis), .otg_o(seq_otg));

  assign gate_a_o   = !ot_q && (slave_q ? slv_a_q : seq_a);
  assign gate_b_o   = !ot_q && (slave_q ? slv_b_q : seq_b);
  assign dischg_o   = !ot_q && !slave_q && seq_dis;
  assign otg_rev_o  = !ot_q && !slave_q && seq_otg;
  assign b_pin_pd_o = !slave_q && !gate_b_o;

  // R12: both switches only on an explicit enable-both request
  assert_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a_o && gate_b_o) |-> (slave_q && pin_q));

  // R11: over-temperature clears both gates at the next edge
  assert_ot_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    over_temp_i |=> (!gate_a_o && !gate_b_o));

endmodule

// File: tb/psel_arbiter_bench.sv
module psel_arbiter_bench;
  localparam int unsigned DEB = 4, LDG = 3, BBM = 6, WB = 8, WNB = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic a_ok = 0, b_ok = 0, out_ok = 0, mode = 0, lock = 0, a_en = 0, pin = 0, ot = 0;
  logic ga, gb, dis, otg, pd;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  psel_arbiter #(.DEB_CYC(DEB), .LOCK_CYC(LDG), .BBM_CYC(BBM),
                 .OTG_WAIT_B(WB), .OTG_WAIT_NB(WNB)) u_psel_arbiter (
    .clk(clk), .rst_n(rst_n), .a_ok_i(a_ok), .b_ok_i(b_ok), .out_ok_i(out_ok),
    .mode_slave_i(mode), .lock_i(lock), .a_en_i(a_en), .b_pin_i(pin),
    .over_temp_i(ot), .gate_a_o(ga), .gate_b_o(gb), .dischg_o(dis),
    .otg_rev_o(otg), .b_pin_pd_o(pd));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R5", "gate_a reset", ga, 0); chk("R5", "gate_b reset", gb, 0);
    chk("R5", "dischg reset", dis, 0); chk("R10", "otg reset", otg, 0);
    chk("R8", "pd reset", pd, 1);
  endtask

  task automatic t_debounce();
    a_ok = 1; step(DEB - 1); a_ok = 0; step(2);
    chk("R2", "short pulse ignored", ga, 0);
    a_ok = 1; step(DEB);
    chk("R2", "not before debounce", ga, 0);
    step(1);
    chk("R2", "on after debounce", ga, 1);
  endtask

  task automatic t_priority();
    b_ok = 1; pin = 1; step(DEB + 3);
    chk("R3", "A keeps priority", ga, 1);
    chk("R8", "pin ignored in autonomous", gb, 0);
    chk("R8", "pd while B off", pd, 1);
    pin = 0;
  endtask

  task automatic t_drop_bbm();
    a_ok = 0; step(1);
    chk("R4", "A off next edge", ga, 0);
    chk("R5", "discharge starts", dis, 1);
    step(BBM - 1);
    chk("R5", "discharge at end of gap", dis, 1);
    chk("R5", "B still off in gap", gb, 0);
    step(1);
    chk("R5", "discharge ends", dis, 0);
    chk("R5", "B off one more cycle", gb, 0);
    step(1);
    chk("R3", "fallback to B", gb, 1);
    chk("R8", "pd released while B on", pd, 0);
  endtask

  task automatic t_return();
    a_ok = 1; step(DEB);
    chk("R3", "B until A qualified", gb, 1);
    step(1);
    chk("R3", "B leaves for A", gb, 0);
    chk("R5", "gap on return", dis, 1);
    step(BBM);
    chk("R5", "A off after gap", ga, 0);
    chk("R5", "discharge off in idle", dis, 0);
    step(1);
    chk("R3", "A back on", ga, 1);
  endtask

  task automatic t_lock();
    lock = 1; step(LDG - 1); lock = 0;
    a_ok = 0; step(1);
    chk("R6", "gap starts", dis, 1);
    step(BBM + 1);
    chk("R6", "short lock pulse ignored", gb, 1);
    lock = 1; step(LDG + 1);
    a_ok = 1; step(DEB + BBM + 4);
    chk("R6", "locked stays on B", gb, 1);
    chk("R6", "locked A blocked", ga, 0);
    b_ok = 0; step(1);
    chk("R4", "B off next edge", gb, 0);
    step(BBM + DEB + 4);
    chk("R7", "locked, A not entered", ga, 0);
    b_ok = 1; step(DEB);
    chk("R7", "B not yet re-qualified", gb, 0);
    step(1);
    chk("R7", "B re-entered", gb, 1);
    lock = 0; step(LDG + BBM + 1);
    chk("R6", "A off until gap ends", ga, 0);
    step(1);
    chk("R6", "unlock lets A in", ga, 1);
  endtask

  task automatic t_ot();
    ot = 1; step(1);
    chk("R11", "OT cuts A", ga, 0);
    step(2);
    chk("R11", "OT holds off", ga, 0); chk("R11", "no discharge in OT", dis, 0);
    ot = 0; step(1);
    chk("R11", "still off one edge after clear", ga, 0);
    step(1);
    chk("R11", "resumes", ga, 1);
  endtask

  task automatic t_otg();
    a_ok = 0; b_ok = 0; step(BBM + 3);
    out_ok = 1; a_en = 1; step(WNB);
    chk("R10", "short wait not done", ga, 0);
    step(1);
    chk("R10", "reverse on (no B)", ga, 1); chk("R10", "otg flag", otg, 1);
    a_en = 0; step(1);
    chk("R10", "reverse off", otg, 0); chk("R10", "gap after reverse", dis, 1);
    step(BBM + 1);
    b_ok = 1; a_en = 1; step(WB);
    chk("R10", "long wait not done", ga, 0); chk("R10", "B ignored in wait", gb, 0);
    step(1);
    chk("R10", "reverse on (B present)", otg, 1); chk("R12", "B off in reverse", gb, 0);
    a_en = 0; out_ok = 0; step(1);
    chk("R10", "A off", ga, 0);
    step(BBM);
    chk("R5", "B off until gap over", gb, 0);
    step(1);
    chk("R3", "B after reverse", gb, 1);
  endtask

  task automatic t_slave();
    a_ok = 1; mode = 1; step(1);
    chk("R1", "slave drops B without pin", gb, 0);
    chk("R8", "pin released in slave", pd, 0);
    step(DEB + 1);
    chk("R9", "A off without enable", ga, 0);
    a_en = 1; step(1);
    chk("R9", "A direct enable", ga, 1); chk("R9", "B stays off", gb, 0);
    pin = 1; step(1);
    chk("R12", "both on via pin A", ga, 1); chk("R12", "both on via pin B", gb, 1);
    a_en = 0; step(1);
    chk("R9", "pin alone enables A", ga, 1);
    pin = 0; step(1);
    chk("R9", "pin low A off", ga, 0); chk("R9", "pin low B off", gb, 0);
    mode = 0; step(1);
    chk("R1", "autonomous starts idle", ga, 0);
    step(1);
    chk("R1", "autonomous selects A", ga, 1); chk("R8", "pd with B off", pd, 1);
  endtask

  initial begin
    step(3); rst_n = 1; step(1);
    t_reset(); t_debounce(); t_priority(); t_drop_bbm(); t_return();
    t_lock(); t_ot(); t_otg(); t_slave();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule